// File: doc/BRIEF.md
# Power Mode and Clock Gating Manager

This block holds the system power mode and turns it into clock enables for three domains: the CPU, the bus/peripheral fabric and the display. It also produces a select that moves the system clock onto the low-frequency reference with the PLL bypassed. Software picks a mode by writing a mode code, qualified by a one-cycle write strobe. Hardware brings the system back to normal operation when a wake event arrives. The block only produces enable and select levels. Downstream gating cells and clock muxes act on them.

Five modes exist, and each has its own gating pattern:
- **Full run**: every domain is running.
- **Reduced-rate**: every domain runs from the slow reference.
- **CPU idle**: only the CPU domain is stopped.
- **Deep stop**: every domain is stopped.
- **Display retention**: only the display domain keeps running.

Leaving deep stop needs one of the eight external interrupt lines or the real-time-clock alarm. After such a wake, the block counts a programmable number of reference cycles, so that the PLL can settle before any clock comes back.

The per-block enable vector lets software gate each peripheral clock on its own. A block clock runs only while its configuration bit is set and the bus domain is running. All pins are plain control levels, with no data stream, so there is no valid/ready handshake.

Top module: `pmm_top`

## Requirements
- R1: After reset the mode code is 0, the CPU, bus and display enables are 1, and the slow select is 0.
- R2: The mode codes are 0 = full run, 1 = reduced-rate, 2 = CPU idle, 3 = deep stop and 4 = display retention. In codes 0 and 1 all three domain enables are 1. The slow select is 1 in code 1 and 0 in every other code.
- R3: In code 2 the CPU enable is 0, and the bus and display enables are 1.
- R4: In code 3 the CPU, bus and display enables are all 0.
- R5: In code 4 only the display enable is 1.
- R6: A strobed request moves the mode to the requested code on the next clock edge, provided the current code is 0 or 1 and the requested value is 0 to 4. Request values 5 to 7 are ignored. Requests made in codes 2, 3 and 4 are ignored.
- R7: In codes 2 and 4, any one of these returns the mode to code 0 on the next edge: the interrupt-pending input, any external interrupt line, or the alarm.
- R8: In code 3 the interrupt-pending input has no effect. Only an external interrupt line or the alarm starts an exit.
- R9: After a deep-stop wake is sampled, the mode stays at code 3 with all enables 0 for lock_cnt further edges. The mode becomes code 0 on edge lock_cnt+1.
- R10: Bit i of the per-block enable output equals configuration bit i while the bus enable is 1, and it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Mode write strobe |
| req_mode | input | 3 | Requested mode code |
| blk_en_cfg | input | N_BLK | Per-block clock enable configuration |
| lock_cnt | input | LOCK_W | PLL settle wait, in reference cycles |
| ext_irq | input | N_EINT | External interrupt lines |
| rtc_alarm | input | 1 | Alarm pulse |
| irq_pend | input | 1 | Any enabled interrupt pending |
| cpu_clk_en | output | 1 | CPU domain enable |
| bus_clk_en | output | 1 | Bus/peripheral domain enable |
| lcd_clk_en | output | 1 | Display domain enable |
| blk_clk_en | output | N_BLK | Per-block clock enables |
| slow_sel | output | 1 | Low-frequency clock select with PLL bypass |
| mode_code | output | 3 | Current mode code |

## Verification
Every one of the eight request values is written from full run, and again from reduced-rate for the legal codes. This separates accepted codes from ignored ones and checks the gating pattern of each mode.

Each low-power mode is then left through every wake source in turn. The pending-interrupt input is tried alone as well, which tells the deep-stop exit rules apart from the idle ones.

Deep-stop exits are repeated with settle counts from 0 to 3, which pins down the exact edge where the mode returns. Several configuration patterns confirm that the block enables follow the bus domain.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  typedef enum logic [2:0] {
    PM_NORMAL = 3'd0,
    PM_SLOW   = 3'd1,
    PM_IDLE   = 3'd2,
    PM_STOP   = 3'd3,
    PM_DISP   = 3'd4
  } pm_mode_e;

  localparam logic [2:0] PM_MAX_CODE = 3'd4;

  typedef struct packed {
    logic cpu;
    logic bus;
    logic lcd;
    logic slow;
  } pm_gate_t;
endpackage

// File: rtl/pmm_wake.sv
module pmm_wake
  import pmm_pkg::*;
#(
  parameter int N_EINT = 8
) (
  input  pm_mode_e          mode,
  input  logic [N_EINT-1:0] ext_irq,
  input  logic              rtc_alarm,
  input  logic              irq_pend,
  output logic              wake_lp,
  output logic              wake_stop
);
  logic hard_src;
  assign hard_src = (|ext_irq) | rtc_alarm;

  always_comb begin
    wake_lp   = 1'b0;
    wake_stop = 1'b0;
    unique case (mode)
      PM_IDLE, PM_DISP: wake_lp   = hard_src | irq_pend;
      PM_STOP:          wake_stop = hard_src;
      default: ;
    endcase
  end
endmodule

// File: rtl/pmm_lock.sv
module pmm_lock #(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LOCK_W-1:0] lock_cnt,
  output logic              busy,
  output logic              done
);
  logic [LOCK_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= lock_cnt;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = busy && (cnt_q == '0);
endmodule

// File: rtl/pmm_gate.sv
module pmm_gate
  import pmm_pkg::*;
#(
  parameter int N_BLK = 4
) (
  input  pm_mode_e         mode,
  input  logic [N_BLK-1:0] blk_en_cfg,
  output pm_gate_t         gate,
  output logic [N_BLK-1:0] blk_clk_en
);
  always_comb begin
    gate = '{cpu: 1'b0, bus: 1'b0, lcd: 1'b0, slow: 1'b0};
    unique case (mode)
      PM_NORMAL: gate = '{cpu: 1'b1, bus: 1'b1, lcd: 1'b1, slow: 1'b0};
      PM_SLOW:   gate = '{cpu: 1'b1, bus: 1'b1, lcd: 1'b1, slow: 1'b1};
      PM_IDLE:   gate = '{cpu: 1'b0, bus: 1'b1, lcd: 1'b1, slow: 1'b0};
      PM_DISP:   gate = '{cpu: 1'b0, bus: 1'b0, lcd: 1'b1, slow: 1'b0};
      default:   gate = '{cpu: 1'b0, bus: 1'b0, lcd: 1'b0, slow: 1'b0};
    endcase
  end

  for (genvar i = 0; i < N_BLK; i++) begin : g_blk
    assign blk_clk_en[i] = blk_en_cfg[i] & gate.bus;
  end
endmodule

// File: rtl/pmm_top.sv
module pmm_top
  import pmm_pkg::*;
#(
  parameter int N_BLK  = 4,
  parameter int LOCK_W = 8,
  parameter int N_EINT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_mode,
  input  logic [N_BLK-1:0]  blk_en_cfg,
  input  logic [LOCK_W-1:0] lock_cnt,
  input  logic [N_EINT-1:0] ext_irq,
  input  logic              rtc_alarm,
  input  logic              irq_pend,
  output logic              cpu_clk_en,
  output logic              bus_clk_en,
  output logic              lcd_clk_en,
  output logic [N_BLK-1:0]  blk_clk_en,
  output logic              slow_sel,
  output logic [2:0]        mode_code
);
  pm_mode_e mode_q;
  pm_gate_t gate;
  logic     wake_lp, wake_stop;
  logic     lock_busy, lock_done, lock_start;
  logic     req_ok;

  pmm_wake #(.N_EINT(N_EINT)) u_wake (
    .mode(mode_q), .ext_irq(ext_irq), .rtc_alarm(rtc_alarm),
    .irq_pend(irq_pend), .wake_lp(wake_lp), .wake_stop(wake_stop)
  );

  assign lock_start = wake_stop && !lock_busy;

  pmm_lock #(.LOCK_W(LOCK_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .start(lock_start), .lock_cnt(lock_cnt),
    .busy(lock_busy), .done(lock_done)
  );

  assign req_ok = req_valid && (mode_q == PM_NORMAL || mode_q == PM_SLOW)
                  && (req_mode <= PM_MAX_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= PM_NORMAL;
    else if (lock_done) mode_q <= PM_NORMAL;
    else if (wake_lp)   mode_q <= PM_NORMAL;
    else if (req_ok)    mode_q <= pm_mode_e'(req_mode);
  end

  pmm_gate #(.N_BLK(N_BLK)) u_gate (
    .mode(mode_q), .blk_en_cfg(blk_en_cfg), .gate(gate), .blk_clk_en(blk_clk_en)
  );

  assign cpu_clk_en = gate.cpu;
  assign bus_clk_en = gate.bus;
  assign lcd_clk_en = gate.lcd;
  assign slow_sel   = gate.slow;
  assign mode_code  = mode_q;
endmodule

// File: rtl/pmm_checker.sv
module pmm_checker #(
  parameter int N_BLK  = 4,
  parameter int N_EINT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_mode,
  input logic [N_EINT-1:0] ext_irq,
  input logic              rtc_alarm,
  input logic              irq_pend,
  input logic              cpu_clk_en,
  input logic              bus_clk_en,
  input logic              lcd_clk_en,
  input logic [N_BLK-1:0]  blk_clk_en,
  input logic              slow_sel,
  input logic [2:0]        mode_code,
  input logic              lock_busy
);
  p_slow_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slow_sel |-> (cpu_clk_en && bus_clk_en && lcd_clk_en));

  p_idle_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd2) |-> (!cpu_clk_en && bus_clk_en && lcd_clk_en));

  p_stop_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd3) |-> (!cpu_clk_en && !bus_clk_en && !lcd_clk_en));

  p_disp_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd4) |-> (!cpu_clk_en && !bus_clk_en && lcd_clk_en));

  p_bad_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode > 3'd4 && mode_code <= 3'd1) |=> $stable(mode_code));

  p_lp_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_code == 3'd2 || mode_code == 3'd4) && irq_pend) |=> (mode_code == 3'd0));

  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd3 && !lock_busy && !(|ext_irq) && !rtc_alarm) |=> (mode_code == 3'd3));

  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy |-> (mode_code == 3'd3 && !cpu_clk_en));

  p_blk_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|blk_clk_en) |-> bus_clk_en);
endmodule

bind pmm_top pmm_checker #(.N_BLK(N_BLK), .N_EINT(N_EINT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .ext_irq(ext_irq), .rtc_alarm(rtc_alarm), .irq_pend(irq_pend),
  .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en), .lcd_clk_en(lcd_clk_en),
  .blk_clk_en(blk_clk_en), .slow_sel(slow_sel), .mode_code(mode_code),
  .lock_busy(lock_busy)
);

// File: tb/pmm_top_test.sv
module pmm_top_test;
  localparam int NB = 4;
  localparam int LW = 8;
  localparam int NE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_mode = '0;
  logic [NB-1:0] blk_en_cfg = '1;
  logic [LW-1:0] lock_cnt = '0;
  logic [NE-1:0] ext_irq = '0;
  logic          rtc_alarm = 1'b0;
  logic          irq_pend = 1'b0;
  logic          cpu_clk_en, bus_clk_en, lcd_clk_en, slow_sel;
  logic [NB-1:0] blk_clk_en;
  logic [2:0]    mode_code;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pmm_top #(.N_BLK(NB), .LOCK_W(LW), .N_EINT(NE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .blk_en_cfg(blk_en_cfg), .lock_cnt(lock_cnt), .ext_irq(ext_irq),
    .rtc_alarm(rtc_alarm), .irq_pend(irq_pend), .cpu_clk_en(cpu_clk_en),
    .bus_clk_en(bus_clk_en), .lcd_clk_en(lcd_clk_en), .blk_clk_en(blk_clk_en),
    .slow_sel(slow_sel), .mode_code(mode_code)
  );

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      report();
      $finish;
    end
  end

  // Check every output against the pattern implied by mode m (R2-R5, R10).
  task automatic check_mode(input logic [2:0] m, input string req);
    logic [3:0] exp_g;   // cpu,bus,lcd,slow
    logic [6+NB:0] act, exp;
    case (m)
      3'd0: exp_g = 4'b1110;
      3'd1: exp_g = 4'b1111;
      3'd2: exp_g = 4'b0110;
      3'd3: exp_g = 4'b0000;
      default: exp_g = 4'b0010;
    endcase
    act = {mode_code, cpu_clk_en, bus_clk_en, lcd_clk_en, slow_sel, blk_clk_en};
    exp = {m, exp_g, (exp_g[2] ? blk_en_cfg : {NB{1'b0}})};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_mode(input logic [2:0] v);
    req_valid = 1'b1;
    req_mode  = v;
    tick();
    req_valid = 1'b0;
  endtask

  // Leave deep stop via a hard source, settle count L (R9).
  task automatic stop_exit(input int src, input int L);
    lock_cnt = LW'(L);
    if (src < NE) ext_irq[src] = 1'b1;
    else          rtc_alarm = 1'b1;
    tick();
    ext_irq = '0;
    rtc_alarm = 1'b0;
    check_mode(3'd3, "R9 lock start");
    for (int k = 0; k < L; k++) begin
      tick();
      check_mode(3'd3, "R9 lock hold");
    end
    tick();
    check_mode(3'd0, "R9 lock end");
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check_mode(3'd0, "R1 in reset");
    rst_n = 1'b1;
    tick();
    check_mode(3'd0, "R1 after reset");

    // R6: sweep all request values from full run and reduced-rate.
    for (int base = 0; base < 2; base++) begin
      for (int v = 0; v < 8; v++) begin
        if (base == 1) begin
          write_mode(3'd1);
          check_mode(3'd1, "R2 slow entry");
        end
        write_mode(3'(v));
        if (v > 4) check_mode(base == 1 ? 3'd1 : 3'd0, "R6 bad code ignored");
        else       check_mode(3'(v), "R6 request accepted");
        case (v)
          2, 4: begin
            write_mode(3'd0);
            check_mode(3'(v), "R6 request ignored in low power");
            irq_pend = 1'b1;
            tick();
            irq_pend = 1'b0;
            check_mode(3'd0, "R7 pending wake");
          end
          3: begin
            write_mode(3'd0);
            check_mode(3'd3, "R6 request ignored in stop");
            stop_exit(NE, 0);
          end
          default: begin
            write_mode(3'd0);
            check_mode(3'd0, "R6 back to full run");
          end
        endcase
      end
    end

    // R7: every hard source wakes idle and display retention.
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s <= NE; s++) begin
        write_mode(m == 0 ? 3'd2 : 3'd4);
        if (s < NE) ext_irq[s] = 1'b1;
        else        rtc_alarm = 1'b1;
        tick();
        ext_irq = '0;
        rtc_alarm = 1'b0;
        check_mode(3'd0, "R7 source wake");
      end
    end

    // R8/R9: pending ignored in stop; every hard source with settle 0..3.
    for (int L = 0; L < 4; L++) begin
      for (int s = 0; s <= NE; s++) begin
        write_mode(3'd3);
        check_mode(3'd3, "R4 stop entry");
        irq_pend = 1'b1;
        tick();
        tick();
        irq_pend = 1'b0;
        check_mode(3'd3, "R8 pending ignored");
        stop_exit(s, L);
      end
    end

    // R10: configuration patterns across modes.
    for (int p = 0; p < (1 << NB); p += 5) begin
      blk_en_cfg = NB'(p);
      for (int m = 0; m < 5; m++) begin
        write_mode(3'(m));
        check_mode(3'(m), "R10 block enables");
        if (m == 3) stop_exit(0, 1);
        else if (m >= 2) begin
          rtc_alarm = 1'b1;
          tick();
          rtc_alarm = 1'b0;
        end
      end
    end

    report();
    $finish;
  end
endmodule